// File: doc/BRIEF.md
# ADC Conversion Sequencer with Latched Channel Selection

This block controls a successive-approximation ADC. Software writes a channel number and a reference choice, an enable bit, a start bit and an auto-trigger enable. The block then runs single conversions, conversions started by an external trigger edge, or back-to-back free-running conversions. All sequencing advances on a one-cycle ADC clock tick enable, and everything runs in the system clock domain.

The programmed selection is not used directly. A shadow copy follows it only while an update window is open. Each conversion captures the shadow copy at the instant it starts, so a result always reports the channel and reference it was sampled with. In free-running mode the conversion that is already under way when software changes the channel still reports the old one.

The analog comparator is replaced by a digital stand-in. It gives every channel a fixed input level and converts that level against the selected reference. The stand-in exists so the sequencing can be tested.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_flag`, `suspect` and `result` are all 0.
- R2: A software start (`start_we` while `en`=1 and idle) is registered at one edge. The conversion begins on the next ADC tick and completes on the 13th tick after the tick that began it. The first conversion after `en` rises takes 25 ticks instead. `busy_o` reads 1 from the start write until completion, which is 14 (or 26) consecutive ticks, and then returns to 0 in single mode.
- R3: `result` = floor(level*1024/ref), where level = (channel+1)*450 mV. The `sel_ref` encoding is 0 = supply at 5000 mV, 1 = internal 1100 mV, 2 = internal 2560 mV, 3 = external pin at 3000 mV. `res_ch` and `res_ref` report the selection the result was sampled with.
- R4: When the channel level is at or above the reference, `result` is 0x3FF.
- R5: A selection write during a conversion does not change that conversion's result. The new selection applies from the next conversion.
- R6: While `en` and `auto_en` are both 1, the shadow selection follows the written one only if a conversion has run at least one tick past its start or `done_flag` is set. Otherwise a write made while idle with the flag clear is not used by the next triggered conversion.
- R7: In free-running mode (`auto_en`=1, `trig_src`=0), each completion edge also starts the next conversion, so completions are exactly 13 ticks apart. Dropping `auto_en` lets the running conversion finish and then stops.
- R8: In free-running mode, a channel write made just after a completion leaves the next result on the old channel. The result after that uses the new channel.
- R9: With `auto_en`=1 and `trig_src`=1, a rising edge on `trig_in` while idle starts a conversion. Edges that arrive while converting are ignored.
- R10: `suspect` is 1 for a result whose reference differs from the reference of the conversion before it. The reference assumed before the first conversion is the supply.
- R11: `done_flag` is set on completion and cleared by `flag_clr`. If both happen at the same edge, completion wins.
- R12: Driving `en` low aborts a conversion with no completion. The next conversion then takes 25 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_tick | input | 1 | One-cycle ADC clock tick enable |
| en | input | 1 | Converter enable |
| auto_en | input | 1 | Auto-trigger enable |
| trig_src | input | 1 | 0 = free-running, 1 = external trigger edge |
| trig_in | input | 1 | External trigger input |
| sel_we | input | 1 | Selection register write strobe |
| sel_ch | input | CH_W | Channel to write |
| sel_ref | input | 2 | Reference select to write |
| start_we | input | 1 | Write one to the start bit |
| flag_clr | input | 1 | Clear the completion flag |
| busy_o | output | 1 | Start bit readback (start pending or converting) |
| done_flag | output | 1 | Completion flag |
| result | output | RES_W | Conversion result |
| res_ch | output | CH_W | Channel the result was sampled with |
| res_ref | output | 2 | Reference the result was sampled with |
| suspect | output | 1 | Result follows a reference switch and should be discarded |

## Verification
The hardest state to reach is the closed update window. It needs enable and auto-trigger both high, no conversion running and the completion flag clear. The stimulus reaches it by switching to external-trigger mode, clearing the flag, writing a new channel and only then pulsing the trigger, so the result must still carry the previous channel. The free-running case is similar. The channel write has to land in the few cycles just after a completion edge, and the bench reaches it by acting on the negative edge that first shows the flag. It then checks two consecutive results and their 13-tick spacing.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    VR_SUPPLY = 2'd0,
    VR_INT_LO = 2'd1,
    VR_INT_HI = 2'd2,
    VR_PIN    = 2'd3
  } vref_e;

  // reference level in millivolts for a given select value
  function automatic int vref_level_mv(vref_e s, int supply_mv, int pin_mv);
    case (s)
      VR_SUPPLY: return supply_mv;
      VR_INT_LO: return 1100;
      VR_INT_HI: return 2560;
      default:   return pin_mv;
    endcase
  endfunction

  // stand-in input level of a channel, in millivolts
  function automatic int chan_level_mv(int ch, int step_mv);
    return (ch + 1) * step_mv;
  endfunction

  // ideal converter transfer: saturates at full scale
  function automatic int sar_code(int lvl_mv, int vr_mv, int res_w);
    int full;
    full = (1 << res_w) - 1;
    if (lvl_mv >= vr_mv) return full;
    return (lvl_mv << res_w) / vr_mv;
  endfunction

endpackage

// File: rtl/adc_seq_shadow.sv
module adc_seq_shadow #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_we,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [1:0]      wr_ref,
  input  logic            open,
  output logic [CH_W-1:0] sh_ch,
  output logic [1:0]      sh_ref
);

  logic [CH_W-1:0] prog_ch;
  logic [1:0]      prog_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_ch  <= '0;
      prog_ref <= '0;
    end else if (sel_we) begin
      prog_ch  <= wr_ch;
      prog_ref <= wr_ref;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_ch  <= '0;
      sh_ref <= '0;
    end else if (open) begin
      sh_ch  <= prog_ch;
      sh_ref <= prog_ref;
    end
  end

  assert_hold_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> ($stable(sh_ch) && $stable(sh_ref)));

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int LEN_NORM  = 13,
  parameter int LEN_FIRST = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic go,
  input  logic restart,
  input  logic long_req,
  output logic busy,
  output logic past_first,
  output logic conv_start,
  output logic conv_done
);

  localparam int CNT_W = $clog2(LEN_FIRST);

  logic [CNT_W-1:0] cnt_q;
  logic             long_q;
  logic [CNT_W-1:0] last_idx;

  assign last_idx   = long_q ? CNT_W'(LEN_FIRST - 1) : CNT_W'(LEN_NORM - 1);
  assign conv_done  = tick & en & busy & (cnt_q == last_idx);
  assign conv_start = tick & en & ((~busy & go) | (conv_done & restart));
  assign past_first = busy & (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (!en) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (conv_start) begin
      busy   <= 1'b1;
      cnt_q  <= '0;
      long_q <= long_req;
    end else if (conv_done) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
    end else if (tick && busy) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= CNT_W'(LEN_FIRST - 1)));

  assert_free_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && restart) |=> (busy && cnt_q == '0));

endmodule

// File: rtl/adc_seq_conv.sv
module adc_seq_conv
  import adc_seq_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int RES_W     = 10,
  parameter int STEP_MV   = 450,
  parameter int SUPPLY_MV = 5000,
  parameter int EXT_MV    = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             conv_start,
  input  logic             conv_done,
  input  logic [CH_W-1:0]  sh_ch,
  input  logic [1:0]       sh_ref,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  res_ch,
  output logic [1:0]       res_ref,
  output logic             suspect
);

  localparam logic [RES_W-1:0] FULL = '1;

  logic [CH_W-1:0] cv_ch;
  vref_e           cv_ref;
  vref_e           last_ref;
  logic            cv_susp;
  int              lvl_mv;
  int              vr_mv;
  int              code_v;
  logic            lvl_ge_ref;

  always_comb begin
    lvl_mv     = chan_level_mv(int'(cv_ch), STEP_MV);
    vr_mv      = vref_level_mv(cv_ref, SUPPLY_MV, EXT_MV);
    code_v     = sar_code(lvl_mv, vr_mv, RES_W);
    lvl_ge_ref = (lvl_mv >= vr_mv);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cv_ch    <= '0;
      cv_ref   <= VR_SUPPLY;
      last_ref <= VR_SUPPLY;
      cv_susp  <= 1'b0;
    end else if (conv_start) begin
      cv_ch    <= sh_ch;
      cv_ref   <= vref_e'(sh_ref);
      cv_susp  <= (vref_e'(sh_ref) != last_ref);
      last_ref <= vref_e'(sh_ref);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      res_ch  <= '0;
      res_ref <= '0;
      suspect <= 1'b0;
    end else if (conv_done) begin
      result  <= RES_W'(code_v);
      res_ch  <= cv_ch;
      res_ref <= cv_ref;
      suspect <= cv_susp;
    end
  end

  assert_sel_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_start) |=> ($stable(cv_ch) && $stable(cv_ref)));

  assert_full_scale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && lvl_ge_ref) |=> (result == FULL));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int RES_W     = 10,
  parameter int LEN_NORM  = 13,
  parameter int LEN_FIRST = 25,
  parameter int STEP_MV   = 450,
  parameter int SUPPLY_MV = 5000,
  parameter int EXT_MV    = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_tick,
  input  logic             en,
  input  logic             auto_en,
  input  logic             trig_src,
  input  logic             trig_in,
  input  logic             sel_we,
  input  logic [CH_W-1:0]  sel_ch,
  input  logic [1:0]       sel_ref,
  input  logic             start_we,
  input  logic             flag_clr,
  output logic             busy_o,
  output logic             done_flag,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  res_ch,
  output logic [1:0]       res_ref,
  output logic             suspect
);

  logic            tm_busy;
  logic            past_first;
  logic            conv_start;
  logic            conv_done;
  logic            start_pend;
  logic            first_pend;
  logic            done_q;
  logic            trig_d;
  logic [CH_W-1:0] sh_ch;
  logic [1:0]      sh_ref;

  // named internal events
  wire trig_rise = trig_in & ~trig_d;
  wire restart   = en & auto_en & ~trig_src;
  wire win_open  = ~en | ~auto_en | past_first | done_q;
  wire sw_start  = start_we & en & ~tm_busy;
  wire hw_start  = trig_rise & en & auto_en & trig_src & ~tm_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_d     <= 1'b0;
      start_pend <= 1'b0;
      first_pend <= 1'b1;
      done_q     <= 1'b0;
    end else begin
      trig_d <= trig_in;
      if (!en || conv_start) start_pend <= 1'b0;
      else if (sw_start || hw_start) start_pend <= 1'b1;
      if (!en) first_pend <= 1'b1;
      else if (conv_start) first_pend <= 1'b0;
      if (conv_done) done_q <= 1'b1;
      else if (flag_clr) done_q <= 1'b0;
    end
  end

  assign busy_o    = start_pend | tm_busy;
  assign done_flag = done_q;

  adc_seq_shadow #(.CH_W(CH_W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_we (sel_we),
    .wr_ch  (sel_ch),
    .wr_ref (sel_ref),
    .open   (win_open),
    .sh_ch  (sh_ch),
    .sh_ref (sh_ref)
  );

  adc_seq_timer #(.LEN_NORM(LEN_NORM), .LEN_FIRST(LEN_FIRST)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (adc_tick),
    .en         (en),
    .go         (start_pend),
    .restart    (restart),
    .long_req   (first_pend),
    .busy       (tm_busy),
    .past_first (past_first),
    .conv_start (conv_start),
    .conv_done  (conv_done)
  );

  adc_seq_conv #(
    .CH_W(CH_W), .RES_W(RES_W), .STEP_MV(STEP_MV),
    .SUPPLY_MV(SUPPLY_MV), .EXT_MV(EXT_MV)
  ) u_conv (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (tm_busy),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .sh_ch      (sh_ch),
    .sh_ref     (sh_ref),
    .result     (result),
    .res_ch     (res_ch),
    .res_ref    (res_ref),
    .suspect    (suspect)
  );

  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(tm_busy));

  assert_pend_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_pend |-> !tm_busy);

  assert_done_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && flag_clr) |=> done_q);

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

  localparam int CLK_P    = 10;
  localparam int TICK_DIV = 4;
  localparam int NV       = 8;
  // {channel[2:0], ref[1:0], suspect, code[9:0]}
  localparam logic [15:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b0, 10'd92},
    {3'd3, 2'd0, 1'b0, 10'd368},
    {3'd1, 2'd1, 1'b1, 10'd837},
    {3'd2, 2'd1, 1'b0, 10'd1023},
    {3'd7, 2'd3, 1'b1, 10'd1023},
    {3'd4, 2'd2, 1'b1, 10'd900},
    {3'd6, 2'd3, 1'b1, 10'd1023},
    {3'd6, 2'd0, 1'b1, 10'd645}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_tick = 1'b0;
  logic en = 1'b0, auto_en = 1'b0, trig_src = 1'b0, trig_in = 1'b0;
  logic sel_we = 1'b0, start_we = 1'b0, flag_clr = 1'b0;
  logic [2:0] sel_ch = '0;
  logic [1:0] sel_ref = '0;
  logic busy_o, done_flag, suspect;
  logic [9:0] result;
  logic [2:0] res_ch;
  logic [1:0] res_ref;

  int tests = 0, fails = 0;
  int tick_total = 0, busy_ticks = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .adc_tick(adc_tick), .en(en), .auto_en(auto_en),
    .trig_src(trig_src), .trig_in(trig_in), .sel_we(sel_we), .sel_ch(sel_ch),
    .sel_ref(sel_ref), .start_we(start_we), .flag_clr(flag_clr), .busy_o(busy_o),
    .done_flag(done_flag), .result(result), .res_ch(res_ch), .res_ref(res_ref),
    .suspect(suspect)
  );

  initial begin
    int ph;
    ph = 0;
    forever begin
      @(posedge clk);
      #1;
      ph = (ph == TICK_DIV - 1) ? 0 : ph + 1;
      adc_tick = (ph == 0);
    end
  end

  always @(posedge clk) begin
    if (adc_tick) tick_total <= tick_total + 1;
    if (adc_tick && busy_o) busy_ticks <= busy_ticks + 1;
  end

  function automatic int model_code(int ch, int rf);
    int lvl, vr, code;
    lvl = (ch + 1) * 450;
    case (rf)
      0: vr = 5000;
      1: vr = 1100;
      2: vr = 2560;
      default: vr = 3000;
    endcase
    code = 0;
    for (int b = 9; b >= 0; b--) begin
      if (((code | (1 << b)) * vr) <= lvl * 1024) code = code | (1 << b);
    end
    return code;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_sel(int ch, int rf);
    @(negedge clk);
    sel_ch = 3'(ch); sel_ref = 2'(rf); sel_we = 1'b1;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_we = 1'b1;
    @(negedge clk); start_we = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    cyc(2); trig_in = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic wait_done(string req, output int t);
    int n;
    n = 0;
    while (done_flag !== 1'b1 && n < 800) begin
      @(negedge clk);
      n++;
    end
    t = tick_total;
    if (n >= 800) chk({req, " completion timeout"}, 0, 1);
  endtask

  initial begin
    #(CLK_P * 190000);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t0, t1, t2, b0;
    logic [15:0] v;
    int prev_ref;

    // R1 reset state
    cyc(5);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_flag, 0);
    chk("R1 result", result, 0);
    chk("R1 suspect", suspect, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    chk("R1 busy after release", busy_o, 0);
    en = 1'b1;
    cyc(2);

    // table walk: single conversions (R2 R3 R4 R10 R11)
    prev_ref = 0;
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      write_sel(int'(v[15:13]), int'(v[12:11]));
      cyc(3);
      b0 = busy_ticks;
      pulse_start();
      chk("R2 busy during conversion", busy_o, 1);
      wait_done("R2", t0);
      chk("R2 tick count", busy_ticks - b0, (i == 0) ? 26 : 14);
      chk("R2 busy cleared", busy_o, 0);
      chk("R3 table code", result, int'(v[9:0]));
      chk("R3 bench model", result, model_code(int'(v[15:13]), int'(v[12:11])));
      chk("R3 res_ch", res_ch, int'(v[15:13]));
      chk("R3 res_ref", res_ref, int'(v[12:11]));
      chk("R10 suspect", suspect, int'(v[10]));
      chk("R10 suspect model", suspect, (int'(v[12:11]) != prev_ref) ? 1 : 0);
      if (v[9:0] == 10'h3FF) chk("R4 full scale", result, 1023);
      prev_ref = int'(v[12:11]);
      clr_flag();
      chk("R11 flag cleared", done_flag, 0);
    end

    // R5: selection write during a conversion
    write_sel(0, 0);
    cyc(3);
    pulse_start();
    cyc(12);
    write_sel(5, 0);
    wait_done("R5", t0);
    chk("R5 result keeps old channel", result, model_code(0, 0));
    chk("R5 res_ch old", res_ch, 0);
    clr_flag();
    cyc(3);
    pulse_start();
    wait_done("R5", t0);
    chk("R5 next uses new channel", result, model_code(5, 0));
    chk("R5 res_ch new", res_ch, 5);
    clr_flag();

    // R6 / R9: external trigger with the window closed
    @(negedge clk); auto_en = 1'b1; trig_src = 1'b1;
    cyc(2);
    write_sel(2, 0);
    cyc(6);
    pulse_trig();
    wait_done("R9", t0);
    chk("R6 idle write not used", res_ch, 5);
    chk("R6 result old channel", result, model_code(5, 0));
    clr_flag();
    cyc(3);
    pulse_trig();
    cyc(10);
    chk("R9 converting after trigger", busy_o, 1);
    pulse_trig();
    wait_done("R9", t0);
    chk("R9 second trigger result", result, model_code(2, 0));
    chk("R9 res_ch", res_ch, 2);
    clr_flag();
    cyc(200);
    chk("R9 trigger during busy ignored (flag)", done_flag, 0);
    chk("R9 trigger during busy ignored (busy)", busy_o, 0);

    // R7 / R8: free-running with a mid-run channel change
    @(negedge clk); trig_src = 1'b0;
    cyc(2);
    pulse_start();
    wait_done("R7", t0);
    chk("R8 first free-run result", result, model_code(2, 0));
    write_sel(4, 0);
    clr_flag();
    wait_done("R7", t1);
    chk("R7 spacing", t1 - t0, 13);
    chk("R8 conversion under way keeps old channel", res_ch, 2);
    chk("R8 old channel code", result, model_code(2, 0));
    clr_flag();
    wait_done("R7", t2);
    chk("R7 spacing second", t2 - t1, 13);
    chk("R8 later conversion uses new channel", res_ch, 4);
    chk("R8 new channel code", result, model_code(4, 0));
    @(negedge clk); auto_en = 1'b0;
    clr_flag();
    wait_done("R7", t0);
    clr_flag();
    cyc(120);
    chk("R7 stops after auto_en low", busy_o, 0);
    chk("R7 no further completion", done_flag, 0);

    // R12: abort by enable low
    pulse_start();
    cyc(20);
    chk("R12 converting before abort", busy_o, 1);
    @(negedge clk); en = 1'b0;
    cyc(2);
    chk("R12 busy cleared on abort", busy_o, 0);
    cyc(120);
    chk("R12 no completion after abort", done_flag, 0);
    @(negedge clk); en = 1'b1;
    cyc(2);
    b0 = busy_ticks;
    pulse_start();
    wait_done("R12", t0);
    chk("R12 long conversion after re-enable", busy_ticks - b0, 26);
    chk("R12 result", result, model_code(4, 0));
    clr_flag();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule